// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the initiating side of a two-wire serial management bus used to read and write the 16-bit configuration and status registers of an external Ethernet PHY. A host presents one request: a read/write flag, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit value. The block then produces the whole serial frame on its own. It drives the management clock, drives the data line through an output-enable for a tristate pad, hands the line to the PHY for reads, and returns the read value with an error flag and a one-cycle completion pulse.

Every frame has the same length. It has 32 synchronization bits, 14 command bits and 18 turnaround and data bits, so 64 clock pulses in all, followed by one closing low phase. The management clock half-period is `DIV` system clocks. On a read, the turnaround bit is sampled. When the PHY leaves it high, no device answered. The block still clocks out the rest of the frame, reports an error and returns zero data.

Top module: `mdio_master`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `done_o`=0, `mdc_o`=0, `mdio_oe_o`=1.
- R2: A frame begins with 32 `mdc_o` pulses during which `mdio_o`=1 with `mdio_oe_o`=1.
- R3: Pulses 33..46 carry, MSB first, the start code 01, then the opcode (read=10, write=01), then the 5-bit PHY address, then the 5-bit register number. Each bit is placed on `mdio_o` while `mdc_o` is low and is held over the rising edge.
- R4: On a write, pulses 47..64 carry the turnaround pattern 10 and then the 16 write-data bits MSB first, with `mdio_oe_o`=1 for the whole frame.
- R5: On a read, `mdio_oe_o` is 0 at pulses 47..64 and 1 at pulses 1..46. The release takes place while `mdc_o` is low.
- R6: On a read, `mdio_i` is sampled in the low phase before each of pulses 48..64. The first sample is the turnaround bit. The next 16 samples form `rdata_o`, MSB first.
- R7: If the turnaround sample is 1, the block reports `err_o`=1 and `rdata_o`=0 and still issues all 64 pulses.
- R8: `mdio_oe_o` is 1 again when `done_o` is raised.
- R9: `done_o` is high for exactly one system clock, 129*DIV clocks after the edge that accepts the request. Each `mdc_o` high phase lasts DIV clocks.
- R10: A request raised while `busy_o`=1 is ignored. The frame in progress is unchanged and no second frame follows.
- R11: `err_o` is 0 at the completion of every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a transaction (taken only when idle) |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | 5 | Register number |
| req_wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Read got no response (valid with done_o) |
| rdata_o | output | 16 | Read data (valid with done_o) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value to pad |
| mdio_oe_o | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data line value from pad |

## Verification
The completion pulse is due 129*DIV system clocks after the accepting edge. The bench counts clocks from that edge, samples at falling clock edges, and checks that the pulse arrives on exactly that count and is gone one clock later. Frame contents are captured on each rising edge of `mdc_o`, so the position of each bit is tied to a pulse number and not to a clock count. The bench-side PHY model changes `mdio_i` on each falling edge of `mdc_o`, at least DIV-1 clocks before the block samples it. `rdata_o` and `err_o` are checked in the same cycle as `done_o`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int CMD_BITS  = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL, ST_DONE} mdio_st_e;

  // Serial word sent after the preamble, leftmost bit first.
  function automatic logic [CMD_BITS-1:0] cmd_word(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] wd,
    input logic [1:0]        start_code,
    input logic [1:0]        op_rd,
    input logic [1:0]        op_wr);
    return {start_code, (rd ? op_rd : op_wr), phy, rg, 2'b10,
            (rd ? {DATA_W{1'b0}} : wd)};
  endfunction

  // Value driven in a given slot: ones in the preamble, command word after.
  function automatic logic slot_bit(
    input int unsigned           slot,
    input int unsigned           pre_len,
    input logic [CMD_BITS-1:0]   word);
    int unsigned k;
    if (slot < pre_len) return 1'b1;
    k = (CMD_BITS - 1) - (slot - pre_len);
    return word[k[4:0]];
  endfunction
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (int'(cnt_q) == DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/mdio_rx.sv
module mdio_rx #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= '0;
    else if (clr_i)   q_o <= '0;
    else if (shift_i) q_o <= {q_o[W-2:0], din_i};
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int         DIV        = 4,
  parameter int         PRE_LEN    = 32,
  parameter logic [1:0] START_CODE = 2'b01,
  parameter logic [1:0] OP_RD_CODE = 2'b10,
  parameter logic [1:0] OP_WR_CODE = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_rd_i,
  input  logic [ADDR_W-1:0] req_phy_i,
  input  logic [ADDR_W-1:0] req_reg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  localparam int SLOTS     = PRE_LEN + CMD_BITS;
  localparam int SW        = $clog2(SLOTS);
  localparam int REL_SLOT  = PRE_LEN + 2 + 2 + 2 * ADDR_W;
  localparam int SAMP_SLOT = REL_SLOT + 1;

  mdio_st_e            state_q;
  logic [SW-1:0]       slot_q;
  logic                hi_q;
  logic                rd_q;
  logic [CMD_BITS-1:0] word_q;
  logic [DATA_W:0]     rx_q;

  // Named internal events
  logic in_frame, tick, accept, released, sample_now, last_slot_end, txn_is_read;

  assign in_frame      = (state_q == ST_RUN) || (state_q == ST_TAIL);
  assign accept        = (state_q == ST_IDLE) && req_i;
  assign released      = (state_q == ST_RUN) && rd_q && (int'(slot_q) >= REL_SLOT);
  assign sample_now    = (state_q == ST_RUN) && tick && !hi_q && rd_q
                         && (int'(slot_q) >= SAMP_SLOT);
  assign last_slot_end = (state_q == ST_RUN) && tick && hi_q && (int'(slot_q) == SLOTS - 1);
  assign txn_is_read   = rd_q;

  mdio_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(in_frame), .tick_o(tick));

  mdio_rx #(.W(DATA_W + 1)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr_i(accept), .shift_i(sample_now),
    .din_i(mdio_i), .q_o(rx_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      hi_q    <= 1'b0;
      rd_q    <= 1'b0;
      word_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_RUN;
          slot_q  <= '0;
          hi_q    <= 1'b0;
          rd_q    <= req_rd_i;
          word_q  <= cmd_word(req_rd_i, req_phy_i, req_reg_i, req_wdata_i,
                              START_CODE, OP_RD_CODE, OP_WR_CODE);
        end
        ST_RUN: if (tick) begin
          hi_q <= !hi_q;
          if (last_slot_end)  state_q <= ST_TAIL;
          else if (hi_q)      slot_q  <= slot_q + SW'(1);
        end
        ST_TAIL: if (tick) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign mdc_o     = (state_q == ST_RUN) && hi_q;
  assign mdio_oe_o = !released;
  assign mdio_o    = released ? 1'b0 :
                     (state_q == ST_RUN) ? slot_bit(int'(slot_q), PRE_LEN, word_q) : 1'b1;
  assign err_o     = rd_q && rx_q[DATA_W];
  assign rdata_o   = err_o ? '0 : rx_q[DATA_W-1:0];
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc_o,
  input logic        mdio_oe_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o,
  input logic        txn_is_read
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (mdc_o) hi_cnt <= hi_cnt + 16'd1;
    else            hi_cnt <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && mdio_oe_o && !done_o)); // R1
  AST_RELEASE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe_o) |-> !mdc_o); // R5
  AST_NOREPLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (rdata_o == 16'h0)); // R7
  AST_OE_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> mdio_oe_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_MDC_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc_o) |-> (hi_cnt == 16'(DIV))); // R9
  AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !txn_is_read) |-> !err_o); // R11
endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc_o(mdc_o), .mdio_oe_o(mdio_oe_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
  .txn_is_read(txn_is_read));

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int DIV = 4;
  localparam int EXP_LAT = 129 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_rd = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wd = '0;
  logic busy, done, err, mdc, mdio_out, mdio_oe;
  logic [15:0] rdata;
  logic mdio_in = 1'b1;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mdio_master #(.DIV(DIV)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_rd_i(req_rd),
    .req_phy_i(req_phy), .req_reg_i(req_reg), .req_wdata_i(req_wd),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in));

  // Frame capture on each rising management-clock edge
  logic cap_d [64];
  logic cap_oe[64];
  int   rises = 0, falls = 0;
  logic phy_here = 1'b0, phy_rd = 1'b0;
  logic [15:0] phy_val = '0;

  always @(posedge mdc) begin
    if (rises < 64) begin
      cap_d[rises]  = mdio_out;
      cap_oe[rises] = mdio_oe;
    end
    rises = rises + 1;
  end

  // PHY model: updates the line after each falling edge
  always @(negedge mdc) begin
    #1;
    if (phy_rd && phy_here && falls == 46)                    mdio_in = 1'b0;
    else if (phy_rd && phy_here && falls >= 47 && falls <= 62) mdio_in = phy_val[62 - falls];
    else                                                       mdio_in = 1'b1;
    falls = falls + 1;
  end

  task automatic chk(input string req_tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, exp);
    end
  endtask

  // One transaction, optional second request while busy
  task automatic run_txn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic here, input logic poke);
    int lat;
    logic [13:0] hdr;
    logic [17:0] tail;
    rises = 0; falls = 0;
    phy_rd = rd; phy_here = here; phy_val = wd;
    @(negedge clk);
    req = 1'b1; req_rd = rd; req_phy = phy; req_reg = rg; req_wd = wd;
    @(negedge clk);
    req = 1'b0;
    chk("R1", "busy after accept", {31'b0, busy}, 32'd1);
    lat = 0;
    while (!done && lat < 4000) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 150) begin
        req = 1'b1; req_rd = !rd; req_phy = ~phy; req_reg = ~rg; req_wd = ~wd;
      end
      if (poke && lat == 152) req = 1'b0;
    end
    chk("R9", "done latency", lat, EXP_LAT);
    chk("R8", "oe at done", {31'b0, mdio_oe}, 32'd1);
    if (rd && here)  chk("R6", "read data", {16'b0, rdata}, {16'b0, wd});
    if (rd && !here) chk("R7", "no-reply data", {16'b0, rdata}, 32'd0);
    chk(rd ? (here ? "R6" : "R7") : "R11", "error flag", {31'b0, err},
        {31'b0, rd && !here});
    @(negedge clk);
    chk("R9", "done width", {31'b0, done}, 32'd0);
    repeat (3 * DIV) @(negedge clk);
    chk(rd && !here ? "R7" : "R4", "pulse count", rises, 64);
    if (poke) chk("R10", "stays idle after ignored request", {31'b0, busy}, 32'd0);
    // Preamble
    begin
      logic ok = 1'b1;
      for (int i = 0; i < 32; i++) if (cap_d[i] !== 1'b1 || cap_oe[i] !== 1'b1) ok = 1'b0;
      chk("R2", "preamble ones", {31'b0, ok}, 32'd1);
    end
    // Header, built here bit by bit in transmission order
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
    begin
      logic [13:0] got;
      for (int i = 0; i < 14; i++) got[13 - i] = cap_d[32 + i];
      chk(poke ? "R10" : "R3", "header bits", {18'b0, got}, {18'b0, hdr});
    end
    if (!rd) begin
      logic [17:0] got;
      logic oeall = 1'b1;
      tail = {2'b10, wd};
      for (int i = 0; i < 18; i++) begin
        got[17 - i] = cap_d[46 + i];
        if (cap_oe[46 + i] !== 1'b1) oeall = 1'b0;
      end
      chk(poke ? "R10" : "R4", "write tail", {14'b0, got}, {14'b0, tail});
      chk("R4", "oe held on write", {31'b0, oeall}, 32'd1);
    end else begin
      logic pat = 1'b1;
      for (int i = 0; i < 64; i++) if (cap_oe[i] !== (i < 46)) pat = 1'b0;
      chk("R5", "oe release window", {31'b0, pat}, 32'd1);
    end
  endtask

  task automatic t_reset();
    chk("R1", "reset busy", {31'b0, busy}, 32'd0);
    chk("R1", "reset done", {31'b0, done}, 32'd0);
    chk("R1", "reset mdc", {31'b0, mdc}, 32'd0);
    chk("R1", "reset oe", {31'b0, mdio_oe}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    run_txn(1'b0, 5'h01, 5'h00, 16'hA5C3, 1'b0, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h1F, 16'h8001, 1'b0, 1'b0);
    run_txn(1'b1, 5'h01, 5'h02, 16'h1234, 1'b1, 1'b0);
    run_txn(1'b1, 5'h10, 5'h1E, 16'hFFFF, 1'b1, 1'b0);
    run_txn(1'b1, 5'h07, 5'h11, 16'h8000, 1'b0, 1'b0);
    run_txn(1'b0, 5'h0A, 5'h15, 16'h0F0F, 1'b0, 1'b1);
    run_txn(1'b1, 5'h03, 5'h04, 16'h0001, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule